// File: doc/BRIEF.md
# Physical Address Deduplication Table

This block is a pipeline stage that sits between address generation and the load and store queues. Each memory operation arrives with its physical address. The block hands back a short tag that no other live address holds, so the queues can compare a few tag bits where they would otherwise compare full addresses. The tag is the index of a table slot. That index is an XOR fold of the line address. Two live addresses that fold to the same slot are never allowed to share it: the younger one is held until the older one has left flight. Each slot keeps the line address, a count of the live operations that use it, and the identifier of the youngest live load to that line. A store therefore learns, through its response, which load it may be ordered against, without searching the load queue.

Several lanes are presented in each cycle, in program order, with lane 0 the oldest. Each accepted operation appends one record to a circular change log, and its response reports the position of that record. Retirement releases the oldest record. A flush names a log position: all newer records are undone one per cycle, newest first, and the block reports busy until the undo is finished.

Top module: `pa_dedup`

## Requirements
- R1: The tag of a request is the XOR fold of its line address, which is the address bits from LINE_OFF upward. Line bit b feeds tag bit (b mod IDX_W). For an accepted lane, rsp_valid, rsp_tag and the other response fields appear on the clock edge that follows acceptance.
- R2: A request whose line address equals the address held by a live slot (count nonzero) is accepted with that slot's tag, and the slot's count rises by one.
- R3: A request whose slot is live with a different line address is stalled (req_stall high) until the slot's count has dropped to zero. After that it is accepted with the same tag.
- R4: Lanes are resolved in program order, with lane 0 the oldest. A lane sees every allocation made by older lanes in the same cycle. When a valid lane stalls, every younger valid lane in that cycle also stalls.
- R5: rsp_yld_valid and rsp_yld_id report the youngest live load in the slot before this operation. rsp_yld_valid is 0 when the slot holds no load. An accepted load becomes the youngest load of its slot.
- R6: A slot's count saturates at 2^CNT_W-1. A request that would exceed this limit is stalled.
- R7: Each accepted operation writes one log record. Its rsp_lpos is the log write position, and positions are consecutive in lane order across cycles.
- R8: A retire (ret_valid with ret_tag) releases the oldest log record and decrements the count of that slot. Retires must follow log order and must name a live slot.
- R9: A flush (flush_valid with flush_pos) stalls all requests in its cycle. On the following cycles, busy stays high for one cycle per record between flush_pos and the write position, and all requests stall while busy is high. Each of those cycles undoes one record, newest first, by lowering its slot's count and restoring the youngest load that the record saw.
- R10: A retire and an undo that land in the same cycle on the same slot both take effect, lowering the count by two.
- R11: After reset all counts are zero, the log is empty, rsp_valid is all zero and busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Request present, one bit per lane |
| req_is_store | input | NREQ | 1 = store, 0 = load |
| req_addr | input | NREQ x PA_W | Physical address per lane |
| req_ld_id | input | NREQ x LID_W | Load identifier per lane |
| req_stall | output | NREQ | Lane not accepted this cycle; hold the request |
| busy | output | 1 | Rollback in progress |
| rsp_valid | output | NREQ | Registered response valid per lane |
| rsp_is_store | output | NREQ | Kind of the responded operation |
| rsp_tag | output | NREQ x IDX_W | Deduplicated address tag |
| rsp_yld_valid | output | NREQ | A youngest load existed before this operation |
| rsp_yld_id | output | NREQ x LID_W | Identifier of that youngest load |
| rsp_lpos | output | NREQ x LOG_AW | Log position of the operation |
| ret_valid | input | 1 | Retire the oldest logged operation |
| ret_tag | input | IDX_W | Tag of the retiring operation |
| flush_valid | input | 1 | Start a rollback |
| flush_pos | input | LOG_AW | Log position to roll back to |

## Verification
A retire and a rollback undo can land in the same cycle on the same slot. Both lower that slot's count. The bench provokes this by issuing a flush and then, in the first cycle that busy is high, retiring the oldest record, which belongs to the slot whose record is being undone. The result is judged at the ports: the slot is refilled until its count saturates, and the lane that stalls shows whether the count dropped by two or by only one.

// File: rtl/pa_dedup_pkg.sv
package pa_dedup_pkg;

    // Outcome of resolving one request lane
    typedef enum logic [1:0] {
        LANE_GO    = 2'd0,
        LANE_CLASH = 2'd1,
        LANE_FULL  = 2'd2,
        LANE_HELD  = 2'd3
    } lane_cause_e;

    // XOR fold of a line address onto idx_w bits
    function automatic logic [15:0] fold_index(input logic [63:0] la,
                                               input int la_w,
                                               input int idx_w);
        logic [15:0] r;
        r = '0;
        for (int b = 0; b < 64; b++) begin
            if (b < la_w) r[b % idx_w] = r[b % idx_w] ^ la[b];
        end
        return r;
    endfunction

endpackage

// File: rtl/pa_dedup_resolve.sv
module pa_dedup_resolve
    import pa_dedup_pkg::*;
#(
    parameter int NREQ     = 2,
    parameter int PA_W     = 32,
    parameter int LINE_OFF = 6,
    parameter int IDX_W    = 4,
    parameter int CNT_W    = 3,
    parameter int LID_W    = 5
) (
    input  logic                              held,
    input  logic [NREQ-1:0]                   req_valid,
    input  logic [NREQ-1:0]                   req_is_store,
    input  logic [NREQ-1:0][PA_W-1:0]         req_addr,
    input  logic [NREQ-1:0][LID_W-1:0]        req_ld_id,
    input  logic [(1<<IDX_W)-1:0][CNT_W-1:0]  tbl_cnt,
    input  logic [(1<<IDX_W)-1:0][PA_W-LINE_OFF-1:0] tbl_la,
    input  logic [(1<<IDX_W)-1:0]             tbl_yv,
    input  logic [(1<<IDX_W)-1:0][LID_W-1:0]  tbl_yid,
    output logic [NREQ-1:0]                   acc,
    output logic [NREQ-1:0][IDX_W-1:0]        slot,
    output logic [NREQ-1:0][PA_W-LINE_OFF-1:0] la,
    output logic [NREQ-1:0]                   view_yv,
    output logic [NREQ-1:0][LID_W-1:0]        view_yid,
    output lane_cause_e [NREQ-1:0]            cause
);
    localparam int LA_W = PA_W - LINE_OFF;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_comb begin
        logic                older_stall;
        logic [15:0]         h;
        logic [CNT_W-1:0]    vc;
        logic [LA_W-1:0]     va;
        logic                vyv;
        logic [LID_W-1:0]    vyid;
        older_stall = 1'b0;
        acc      = '0;
        slot     = '0;
        la       = '0;
        view_yv  = '0;
        view_yid = '0;
        cause    = '{default: LANE_HELD};
        for (int i = 0; i < NREQ; i++) begin
            la[i]   = req_addr[i][PA_W-1:LINE_OFF];
            h       = fold_index(64'(la[i]), LA_W, IDX_W);
            slot[i] = h[IDX_W-1:0];
            vc   = tbl_cnt[slot[i]];
            va   = tbl_la[slot[i]];
            vyv  = tbl_yv[slot[i]] & (vc != '0);
            vyid = tbl_yid[slot[i]];
            // apply allocations of older lanes in this cycle
            for (int j = 0; j < NREQ; j++) begin
                if (j < i && acc[j] && slot[j] == slot[i]) begin
                    vc = vc + CNT_W'(1);
                    va = la[j];
                    if (!req_is_store[j]) begin
                        vyv  = 1'b1;
                        vyid = req_ld_id[j];
                    end
                end
            end
            if (held || older_stall)              cause[i] = LANE_HELD;
            else if (vc != '0 && va != la[i])     cause[i] = LANE_CLASH;
            else if (vc == CNT_MAX)               cause[i] = LANE_FULL;
            else                                  cause[i] = LANE_GO;
            acc[i]      = req_valid[i] && (cause[i] == LANE_GO);
            view_yv[i]  = vyv;
            view_yid[i] = vyid;
            if (req_valid[i] && !acc[i]) older_stall = 1'b1;
        end
    end

endmodule

// File: rtl/pa_dedup_table.sv
module pa_dedup_table #(
    parameter int NREQ  = 2,
    parameter int IDX_W = 4,
    parameter int LA_W  = 26,
    parameter int CNT_W = 3,
    parameter int LID_W = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NREQ-1:0]                   acc,
    input  logic [NREQ-1:0][IDX_W-1:0]        slot,
    input  logic [NREQ-1:0][LA_W-1:0]         la,
    input  logic [NREQ-1:0]                   is_store,
    input  logic [NREQ-1:0][LID_W-1:0]        ld_id,
    input  logic                              ret_valid,
    input  logic [IDX_W-1:0]                  ret_slot,
    input  logic                              undo_valid,
    input  logic [IDX_W-1:0]                  undo_slot,
    input  logic                              undo_was_load,
    input  logic                              undo_pyv,
    input  logic [LID_W-1:0]                  undo_pyid,
    output logic [(1<<IDX_W)-1:0][CNT_W-1:0]  ent_cnt,
    output logic [(1<<IDX_W)-1:0][LA_W-1:0]   ent_la,
    output logic [(1<<IDX_W)-1:0]             ent_yv,
    output logic [(1<<IDX_W)-1:0][LID_W-1:0]  ent_yid
);
    localparam int ENTRIES = 1 << IDX_W;
    typedef logic [CNT_W:0] cwide_t;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        cwide_t           inc, dec, sum;
        logic [LA_W-1:0]  la_n;
        logic             yv_n;
        logic [LID_W-1:0] yid_n;

        always_comb begin
            inc   = '0;
            la_n  = ent_la[e];
            yv_n  = (ent_cnt[e] == '0) ? 1'b0 : ent_yv[e];
            yid_n = ent_yid[e];
            for (int i = 0; i < NREQ; i++) begin
                if (acc[i] && slot[i] == IDX_W'(e)) begin
                    inc  = inc + cwide_t'(1);
                    la_n = la[i];
                    if (!is_store[i]) begin
                        yv_n  = 1'b1;
                        yid_n = ld_id[i];
                    end
                end
            end
            if (undo_valid && undo_slot == IDX_W'(e) && undo_was_load) begin
                yv_n  = undo_pyv;
                yid_n = undo_pyid;
            end
            dec = cwide_t'(ret_valid && ret_slot == IDX_W'(e))
                + cwide_t'(undo_valid && undo_slot == IDX_W'(e));
            sum = cwide_t'(ent_cnt[e]) + inc - dec;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_cnt[e] <= '0;
                ent_la[e]  <= '0;
                ent_yv[e]  <= 1'b0;
                ent_yid[e] <= '0;
            end else begin
                ent_cnt[e] <= sum[CNT_W-1:0];
                ent_la[e]  <= la_n;
                ent_yv[e]  <= yv_n;
                ent_yid[e] <= yid_n;
            end
        end
    end

endmodule

// File: rtl/pa_dedup_log.sv
module pa_dedup_log #(
    parameter int NREQ   = 2,
    parameter int IDX_W  = 4,
    parameter int LID_W  = 5,
    parameter int LOG_AW = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NREQ-1:0]             acc,
    input  logic [NREQ-1:0][IDX_W-1:0]  slot,
    input  logic [NREQ-1:0]             is_store,
    input  logic [NREQ-1:0]             view_yv,
    input  logic [NREQ-1:0][LID_W-1:0]  view_yid,
    input  logic                        ret_valid,
    input  logic                        flush_valid,
    input  logic [LOG_AW-1:0]           flush_pos,
    output logic [NREQ-1:0][LOG_AW-1:0] lpos,
    output logic                        room_ok,
    output logic                        busy,
    output logic                        undo_valid,
    output logic [IDX_W-1:0]            undo_slot,
    output logic                        undo_was_load,
    output logic                        undo_pyv,
    output logic [LID_W-1:0]            undo_pyid,
    output logic [IDX_W-1:0]            head_slot
);
    localparam int DEPTH = 1 << LOG_AW;
    localparam int PTR_W = LOG_AW + 1;
    typedef logic [PTR_W-1:0] ptr_t;
    typedef logic [PTR_W:0]   pw_t;

    typedef struct packed {
        logic [IDX_W-1:0] slot;
        logic             was_load;
        logic             pyv;
        logic [LID_W-1:0] pyid;
    } rec_t;

    rec_t              mem [DEPTH];
    ptr_t              head_q, tail_q, tail_dec, npush, used;
    ptr_t [NREQ-1:0]   wr_ptr;
    logic              rolling_q;
    logic [LOG_AW-1:0] target_q;
    rec_t              undo_rec;

    always_comb begin
        npush = '0;
        for (int i = 0; i < NREQ; i++) begin
            wr_ptr[i] = tail_q + npush;
            lpos[i]   = wr_ptr[i][LOG_AW-1:0];
            if (acc[i]) npush = npush + ptr_t'(1);
        end
        used     = tail_q - head_q;
        room_ok  = (pw_t'(used) + pw_t'(NREQ)) <= pw_t'(DEPTH);
        tail_dec = tail_q - ptr_t'(1);
        undo_rec = mem[tail_dec[LOG_AW-1:0]];
    end

    assign busy          = rolling_q;
    assign undo_valid    = rolling_q;
    assign undo_slot     = undo_rec.slot;
    assign undo_was_load = undo_rec.was_load;
    assign undo_pyv      = undo_rec.pyv;
    assign undo_pyid     = undo_rec.pyid;
    assign head_slot     = mem[head_q[LOG_AW-1:0]].slot;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREQ; i++) begin
            if (acc[i]) mem[wr_ptr[i][LOG_AW-1:0]] <= '{slot: slot[i],
                                                        was_load: !is_store[i],
                                                        pyv: view_yv[i],
                                                        pyid: view_yid[i]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q    <= '0;
            tail_q    <= '0;
            rolling_q <= 1'b0;
            target_q  <= '0;
        end else begin
            if (ret_valid) head_q <= head_q + ptr_t'(1);
            if (flush_valid) begin
                rolling_q <= (flush_pos != tail_q[LOG_AW-1:0]);
                target_q  <= flush_pos;
            end else if (rolling_q) begin
                tail_q    <= tail_dec;
                rolling_q <= (tail_dec[LOG_AW-1:0] != target_q);
            end else begin
                tail_q <= tail_q + npush;
            end
        end
    end

endmodule

// File: rtl/pa_dedup.sv
module pa_dedup
    import pa_dedup_pkg::*;
#(
    parameter int NREQ     = 2,
    parameter int PA_W     = 32,
    parameter int LINE_OFF = 6,
    parameter int IDX_W    = 4,
    parameter int CNT_W    = 3,
    parameter int LID_W    = 5,
    parameter int LOG_AW   = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NREQ-1:0]             req_valid,
    input  logic [NREQ-1:0]             req_is_store,
    input  logic [NREQ-1:0][PA_W-1:0]   req_addr,
    input  logic [NREQ-1:0][LID_W-1:0]  req_ld_id,
    output logic [NREQ-1:0]             req_stall,
    output logic                        busy,
    output logic [NREQ-1:0]             rsp_valid,
    output logic [NREQ-1:0]             rsp_is_store,
    output logic [NREQ-1:0][IDX_W-1:0]  rsp_tag,
    output logic [NREQ-1:0]             rsp_yld_valid,
    output logic [NREQ-1:0][LID_W-1:0]  rsp_yld_id,
    output logic [NREQ-1:0][LOG_AW-1:0] rsp_lpos,
    input  logic                        ret_valid,
    input  logic [IDX_W-1:0]            ret_tag,
    input  logic                        flush_valid,
    input  logic [LOG_AW-1:0]           flush_pos
);
    localparam int LA_W    = PA_W - LINE_OFF;
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0][CNT_W-1:0] ent_cnt;
    logic [ENTRIES-1:0][LA_W-1:0]  ent_la;
    logic [ENTRIES-1:0]            ent_yv;
    logic [ENTRIES-1:0][LID_W-1:0] ent_yid;

    logic [NREQ-1:0]              acc;
    logic [NREQ-1:0][IDX_W-1:0]   slot;
    logic [NREQ-1:0][LA_W-1:0]    la;
    logic [NREQ-1:0]              view_yv;
    logic [NREQ-1:0][LID_W-1:0]   view_yid;
    lane_cause_e [NREQ-1:0]       cause;
    logic [NREQ-1:0][LOG_AW-1:0]  lpos;

    logic             room_ok, held;
    logic             undo_valid, undo_was_load, undo_pyv;
    logic [IDX_W-1:0] undo_slot, head_slot;
    logic [LID_W-1:0] undo_pyid;

    // requests wait during a flush cycle, a rollback, or a nearly full log
    assign held      = busy | flush_valid | ~room_ok;
    assign req_stall = req_valid & ~acc;

    pa_dedup_resolve #(
        .NREQ(NREQ), .PA_W(PA_W), .LINE_OFF(LINE_OFF),
        .IDX_W(IDX_W), .CNT_W(CNT_W), .LID_W(LID_W)
    ) u_resolve (
        .held(held), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_addr(req_addr), .req_ld_id(req_ld_id),
        .tbl_cnt(ent_cnt), .tbl_la(ent_la), .tbl_yv(ent_yv), .tbl_yid(ent_yid),
        .acc(acc), .slot(slot), .la(la), .view_yv(view_yv),
        .view_yid(view_yid), .cause(cause)
    );

    pa_dedup_table #(
        .NREQ(NREQ), .IDX_W(IDX_W), .LA_W(LA_W), .CNT_W(CNT_W), .LID_W(LID_W)
    ) u_table (
        .clk(clk), .rst(rst), .acc(acc), .slot(slot), .la(la),
        .is_store(req_is_store), .ld_id(req_ld_id),
        .ret_valid(ret_valid), .ret_slot(ret_tag),
        .undo_valid(undo_valid), .undo_slot(undo_slot),
        .undo_was_load(undo_was_load), .undo_pyv(undo_pyv), .undo_pyid(undo_pyid),
        .ent_cnt(ent_cnt), .ent_la(ent_la), .ent_yv(ent_yv), .ent_yid(ent_yid)
    );

    pa_dedup_log #(
        .NREQ(NREQ), .IDX_W(IDX_W), .LID_W(LID_W), .LOG_AW(LOG_AW)
    ) u_log (
        .clk(clk), .rst(rst), .acc(acc), .slot(slot), .is_store(req_is_store),
        .view_yv(view_yv), .view_yid(view_yid), .ret_valid(ret_valid),
        .flush_valid(flush_valid), .flush_pos(flush_pos), .lpos(lpos),
        .room_ok(room_ok), .busy(busy), .undo_valid(undo_valid),
        .undo_slot(undo_slot), .undo_was_load(undo_was_load),
        .undo_pyv(undo_pyv), .undo_pyid(undo_pyid), .head_slot(head_slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= '0;
            rsp_is_store  <= '0;
            rsp_tag       <= '0;
            rsp_yld_valid <= '0;
            rsp_yld_id    <= '0;
            rsp_lpos      <= '0;
        end else begin
            rsp_valid     <= acc;
            rsp_is_store  <= req_is_store;
            rsp_tag       <= slot;
            rsp_yld_valid <= view_yv;
            rsp_yld_id    <= view_yid;
            rsp_lpos      <= lpos;
        end
    end

endmodule

// File: rtl/pa_dedup_chk.sv
module pa_dedup_chk #(
    parameter int NREQ     = 2,
    parameter int IDX_W    = 4,
    parameter int LA_W     = 26,
    parameter int CNT_W    = 3
) (
    input logic                            clk,
    input logic                            rst,
    input logic [NREQ-1:0]                 req_valid,
    input logic [NREQ-1:0]                 req_stall,
    input logic                            busy,
    input logic [NREQ-1:0]                 acc,
    input logic [NREQ-1:0][IDX_W-1:0]      slot,
    input logic [NREQ-1:0][LA_W-1:0]       la,
    input logic                            ret_valid,
    input logic [IDX_W-1:0]                ret_tag,
    input logic [IDX_W-1:0]                head_slot,
    input logic [(1<<IDX_W)-1:0][CNT_W-1:0] ent_cnt,
    input logic [NREQ-1:0]                 rsp_valid
);
    // R8: a retire must name a live slot (decrement of a zero count is an error)
    assert_no_zero_release_R8: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> ent_cnt[ret_tag] != '0);

    // R8: retires follow log order
    assert_retire_in_order_R8: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> head_slot == ret_tag);

    // R9: nothing is accepted while a rollback runs, and nothing responds after
    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> req_stall == req_valid);
    assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> rsp_valid == '0);

    for (genvar i = 0; i < NREQ; i++) begin : g_lane
        if (i > 0) begin : g_ord
            // R4: a stalled older lane stalls the younger one
            assert_stall_chain_R4: assert property (@(posedge clk) disable iff (rst)
                (req_valid[i] && req_valid[i-1] && req_stall[i-1]) |-> req_stall[i]);
        end
        for (genvar j = 0; j < i; j++) begin : g_pair
            // R3: lanes accepted together on one tag carry one address
            assert_unique_tag_R3: assert property (@(posedge clk) disable iff (rst)
                (acc[i] && acc[j] && slot[i] == slot[j]) |-> la[i] == la[j]);
        end
    end

endmodule

bind pa_dedup pa_dedup_chk #(
    .NREQ(NREQ), .IDX_W(IDX_W), .LA_W(LA_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_stall(req_stall),
    .busy(busy), .acc(acc), .slot(slot), .la(la), .ret_valid(ret_valid),
    .ret_tag(ret_tag), .head_slot(head_slot), .ent_cnt(ent_cnt),
    .rsp_valid(rsp_valid)
);

// File: tb/pa_dedup_bench.sv
module pa_dedup_bench;
    localparam int NREQ = 2, PA_W = 32, LINE_OFF = 6, IDX_W = 4;
    localparam int CNT_W = 3, LID_W = 5, LOG_AW = 4;
    localparam int LA_W = PA_W - LINE_OFF;

    logic clk = 1'b0;
    logic rst;
    logic [NREQ-1:0]             req_valid, req_is_store, req_stall, rsp_valid;
    logic [NREQ-1:0]             rsp_is_store, rsp_yld_valid;
    logic [NREQ-1:0][PA_W-1:0]   req_addr;
    logic [NREQ-1:0][LID_W-1:0]  req_ld_id, rsp_yld_id;
    logic [NREQ-1:0][IDX_W-1:0]  rsp_tag;
    logic [NREQ-1:0][LOG_AW-1:0] rsp_lpos;
    logic                        busy, ret_valid, flush_valid;
    logic [IDX_W-1:0]            ret_tag;
    logic [LOG_AW-1:0]           flush_pos;

    int checks = 0, fails = 0, exp_tail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pa_dedup #(.NREQ(NREQ), .PA_W(PA_W), .LINE_OFF(LINE_OFF), .IDX_W(IDX_W),
               .CNT_W(CNT_W), .LID_W(LID_W), .LOG_AW(LOG_AW)) u_pa_dedup (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_addr(req_addr), .req_ld_id(req_ld_id), .req_stall(req_stall),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_is_store(rsp_is_store),
        .rsp_tag(rsp_tag), .rsp_yld_valid(rsp_yld_valid), .rsp_yld_id(rsp_yld_id),
        .rsp_lpos(rsp_lpos), .ret_valid(ret_valid), .ret_tag(ret_tag),
        .flush_valid(flush_valid), .flush_pos(flush_pos));

    typedef struct packed {
        logic [1:0] v;
        logic [1:0] st;
        logic [7:0] la0;
        logic [7:0] la1;
        logic [1:0] stall;
        logic [1:0] yv;
        logic [4:0] yid0;
        logic [4:0] yid1;
    } vec_t;

    // lane 0 in bit 0; load id of vector k, lane n is 2k+n
    localparam vec_t VECS [6] = '{
        '{2'b11, 2'b10, 8'h03, 8'h03, 2'b00, 2'b10, 5'd0, 5'd0},
        '{2'b11, 2'b00, 8'h30, 8'h05, 2'b11, 2'b00, 5'd0, 5'd0},
        '{2'b10, 2'b00, 8'h00, 8'h05, 2'b00, 2'b00, 5'd0, 5'd0},
        '{2'b11, 2'b11, 8'h50, 8'h03, 2'b11, 2'b00, 5'd0, 5'd0},
        '{2'b11, 2'b00, 8'h07, 8'h70, 2'b10, 2'b00, 5'd0, 5'd0},
        '{2'b11, 2'b11, 8'h07, 8'h07, 2'b00, 2'b11, 5'd8, 5'd8}
    };

    function automatic logic [IDX_W-1:0] exp_tag(input logic [LA_W-1:0] la);
        logic [IDX_W-1:0] t = '0;
        for (int b = 0; b < LA_W; b++) t[b % IDX_W] ^= la[b];
        return t;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one request cycle: drive, judge stall before the edge, judge responses after it
    task automatic cycle(input logic [1:0] v, input logic [1:0] st,
                         input logic [LA_W-1:0] la0, input logic [LA_W-1:0] la1,
                         input int id0, input int id1,
                         input logic [1:0] stall, input logic [1:0] yv,
                         input int yid0, input int yid1, input string req);
        logic [1:0] accd;
        int k;
        @(negedge clk);
        req_valid    = v;
        req_is_store = st;
        req_addr[0]  = {la0, 6'b0};
        req_addr[1]  = {la1, 6'b0};
        req_ld_id[0] = LID_W'(id0);
        req_ld_id[1] = LID_W'(id1);
        #1;
        check(req_stall == stall, {req, " stall"}, int'(req_stall), int'(stall));
        accd = v & ~stall;
        @(posedge clk);
        #1;
        req_valid = '0;
        check(rsp_valid == accd, {req, " rsp_valid R1"}, int'(rsp_valid), int'(accd));
        k = 0;
        for (int i = 0; i < NREQ; i++) begin
            if (accd[i]) begin
                check(rsp_tag[i] == exp_tag(i == 0 ? la0 : la1), {req, " tag R1"},
                      int'(rsp_tag[i]), int'(exp_tag(i == 0 ? la0 : la1)));
                check(rsp_yld_valid[i] == yv[i], {req, " yld valid R5"},
                      int'(rsp_yld_valid[i]), int'(yv[i]));
                if (yv[i])
                    check(int'(rsp_yld_id[i]) == (i == 0 ? yid0 : yid1), {req, " yld id R5"},
                          int'(rsp_yld_id[i]), (i == 0 ? yid0 : yid1));
                check(int'(rsp_lpos[i]) == ((exp_tail + k) % 16), {req, " lpos R7"},
                      int'(rsp_lpos[i]), (exp_tail + k) % 16);
                k++;
            end
        end
        exp_tail += k;
    endtask

    task automatic retire(input logic [IDX_W-1:0] t);
        @(negedge clk);
        ret_valid = 1'b1;
        ret_tag   = t;
        @(posedge clk);
        #1;
        ret_valid = 1'b0;
    endtask

    // flush with a pending load on lane 0; returns the number of busy cycles
    task automatic flush_and_count(input int pos, output int nbusy);
        @(negedge clk);
        flush_valid  = 1'b1;
        flush_pos    = LOG_AW'(pos);
        req_valid    = 2'b01;
        req_is_store = 2'b00;
        req_addr[0]  = {26'h07, 6'b0};
        #1;
        check(req_stall[0] == 1'b1, "flush cycle stall R9", int'(req_stall[0]), 1);
        @(posedge clk);
        #1;
        flush_valid = 1'b0;
        nbusy = 0;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            #1;
            if (!busy) break;
            nbusy++;
            check(req_stall[0] == 1'b1, "stall while busy R9", int'(req_stall[0]), 1);
        end
        req_valid = '0;
        exp_tail = pos;
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int nb;
        rst = 1'b1;
        req_valid = '0; req_is_store = '0; req_addr = '0; req_ld_id = '0;
        ret_valid = 1'b0; ret_tag = '0; flush_valid = 1'b0; flush_pos = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R11: reset state
        check(rsp_valid == '0, "reset rsp_valid R11", int'(rsp_valid), 0);
        check(busy == 1'b0, "reset busy R11", int'(busy), 0);
        check(req_stall == '0, "reset stall R11", int'(req_stall), 0);

        // table walk: R1 R2 R3 R4 R5 R7
        for (int k = 0; k < 6; k++) begin
            cycle(VECS[k].v, VECS[k].st, LA_W'(VECS[k].la0), LA_W'(VECS[k].la1),
                  2 * k, 2 * k + 1, VECS[k].stall, VECS[k].yv,
                  int'(VECS[k].yid0), int'(VECS[k].yid1), $sformatf("vec%0d R2 R3 R4", k));
        end

        // R8 and R3: releasing both ops of slot 3 lets the clashing line in
        retire(4'd3);
        retire(4'd3);
        cycle(2'b01, 2'b00, 26'h30, 26'h0, 20, 0, 2'b00, 2'b00, 0, 0, "after retire R8 R3");

        // R6: slot 7 holds 3, fills to 7, then stalls
        cycle(2'b11, 2'b11, 26'h07, 26'h07, 0, 0, 2'b00, 2'b11, 8, 8, "fill R6");
        cycle(2'b11, 2'b11, 26'h07, 26'h07, 0, 0, 2'b00, 2'b11, 8, 8, "fill R6");
        cycle(2'b11, 2'b11, 26'h07, 26'h07, 0, 0, 2'b11, 2'b00, 0, 0, "saturate R6");

        // R9: roll back four stores, busy for four cycles
        flush_and_count(7, nb);
        check(nb == 4, "busy length R9", nb, 4);
        cycle(2'b01, 2'b00, 26'h07, 26'h0, 30, 0, 2'b00, 2'b01, 8, 0, "load after undo R9");
        flush_and_count(7, nb);
        check(nb == 1, "busy length one R9", nb, 1);
        // youngest load restored to 8, not 30
        cycle(2'b01, 2'b01, 26'h07, 26'h0, 0, 0, 2'b00, 2'b01, 8, 0, "yld restored R9 R5");

        // R10: retire and undo hit slot 7 in the same cycle
        retire(4'd5);
        @(negedge clk);
        flush_valid = 1'b1;
        flush_pos   = 4'd7;
        @(posedge clk);
        #1;
        flush_valid = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "undo cycle busy R10", int'(busy), 1);
        ret_valid = 1'b1;
        ret_tag   = 4'd7;
        @(posedge clk);
        #1;
        ret_valid = 1'b0;
        exp_tail  = 7;
        @(negedge clk);
        #1;
        check(busy == 1'b0, "undo done R10", int'(busy), 0);
        // count is now 2: two full pairs then a single lane fits
        cycle(2'b11, 2'b11, 26'h07, 26'h07, 0, 0, 2'b00, 2'b11, 8, 8, "refill R10");
        cycle(2'b11, 2'b11, 26'h07, 26'h07, 0, 0, 2'b00, 2'b11, 8, 8, "refill R10");
        cycle(2'b11, 2'b11, 26'h07, 26'h07, 0, 0, 2'b10, 2'b01, 8, 0, "double release R10");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule